// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an internal single-word request port and an external asynchronous static RAM. Each accepted request becomes one byte transfer. The transfer uses active-low select, write-enable and output-enable strobes, a 19-bit address and an 8-bit data bus. The bus is split into an output value, a driver enable and an input value, so the pad ring can build the bidirectional pins. The block is clocked by the system clock. Every analogue timing minimum of the memory is given as a parameter in nanoseconds. The block stretches each strobe over a whole number of clocks that covers that minimum. The count is the ceiling of the time divided by the clock period, and any nonzero time costs at least one clock.

The state machine has six states. ST_IDLE is standby with the select high; it accepts requests. ST_READ holds select and output enable low for the read length and samples the bus in its last cycle. ST_TURN keeps every strobe high after a read, so the memory can stop driving the bus. ST_WRITE holds select and write enable low and drives the data. ST_RETAIN is the low-power retention state with the select high. ST_RECOVER is the mandatory wait after retention.

The transitions are as follows. Idle to retain happens when the retention request is high, and this takes priority over a request. Idle to read or to write happens on an accepted request. Read to turn happens when the timer expires, and turn to idle likewise. Write to idle happens when the timer expires. Retain to recover happens when the retention request falls. Recover to idle happens when the timer expires.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the three strobes are high (inactive), the data driver enable is 0, rd_valid is 0, ret_active is 0 and req_ready is 1.
- R2: The strobes follow this encoding. Standby is select 1, write 1, output 1. A read is select 0, output 0, write 1. A write is select 0, write 0, output 1. Write enable and output enable are never low together, and neither is low while the select is high.
- R3: A read holds output enable low for RD_CYC = ceil(max(access, output-valid, cycle time)/period) clocks, which is 4 at the defaults (5 ns clock). The bus is sampled in the last of those clocks. The byte appears on rd_data with rd_valid high for exactly one clock.
- R4: A write holds write enable low for WR_CYC = ceil(max(pulse width, data-to-write, cycle time)/period) clocks, which is 4 at the defaults. The address equals the requested 19-bit address, and the address and data stay stable while write enable is low. The memory stores the requested byte.
- R5: The data driver enable is high only while write enable is low, and never while output enable is low. After a read, output enable has been high for at least TURN_CYC = ceil(float-off time/period) clocks (2 at the defaults) before the driver turns on.
- R6: req_ready is high only in the idle state with no retention request. A request is accepted on a clock where req_valid and req_ready are both high. Only one access is in progress at a time.
- R7: While ret_req is high, the controller enters retention. In retention the select is high, ret_active is 1, req_ready is 0, and a pending request is not started, even when it arrives in the same clock as the retention request.
- R8: After ret_req falls, req_ready stays low for REC_CYC = ceil(recovery time/period) clocks (4 at the defaults) before the next access can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 8 | Read byte |
| ret_req | input | 1 | Level request for retention mode |
| ret_active | output | 1 | Memory held in retention standby |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The assertions check some properties on every clock. They check the legality of the strobe combination. They check that the driver never fights an enabled memory output. They check that address and data are stable inside a write pulse, that rd_valid lasts a single clock, that there is one accepted request at a time, and that the port stays closed at the start of recovery. The strobe lengths, the sampling point relative to access time, the stored and returned bytes and the exact recovery length can only be shown by the bench scenarios. For these the bench uses a memory model that returns garbage until the access time has elapsed and that stores data on the rising write edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_RETAIN,
        ST_RECOVER
    } sram_state_e;

    // Clocks needed to cover t_ns; any nonzero time costs at least one clock.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        if (t_ns == 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= sample;
            if (sample) data <= bus_in;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned T_AA_NS   = 17,
    parameter int unsigned T_OE_NS   = 8,
    parameter int unsigned T_RC_NS   = 17,
    parameter int unsigned T_WP_NS   = 14,
    parameter int unsigned T_DW_NS   = 8,
    parameter int unsigned T_WC_NS   = 17,
    parameter int unsigned T_OHZ_NS  = 7,
    parameter int unsigned T_REC_NS  = 17,
    parameter int          ADDR_W    = 19,
    parameter int          DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ret_req,
    output logic              ret_active,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC = max2(1, max2(ns_to_cycles(T_AA_NS, CLK_NS),
                                      max2(ns_to_cycles(T_OE_NS, CLK_NS),
                                           ns_to_cycles(T_RC_NS, CLK_NS))));
    localparam int unsigned WR_CYC = max2(1, max2(ns_to_cycles(T_WP_NS, CLK_NS),
                                      max2(ns_to_cycles(T_DW_NS, CLK_NS),
                                           ns_to_cycles(T_WC_NS, CLK_NS))));
    localparam int unsigned TURN_CYC = max2(1, ns_to_cycles(T_OHZ_NS, CLK_NS));
    localparam int unsigned REC_CYC  = max2(1, ns_to_cycles(T_REC_NS, CLK_NS));
    localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WR_CYC), max2(TURN_CYC, REC_CYC));
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    sram_state_e       state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              accept;
    logic              cap_en;
    logic              is_write_q;

    assign accept = (state_q == ST_IDLE) && !ret_req && req_valid;
    assign cap_en = (state_q == ST_READ) && tmr_done;

    sram_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (cap_en),
        .bus_in (mem_dq_in),
        .valid  (rd_valid),
        .data   (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            is_write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) is_write_q <= req_write;
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_req) begin
                    state_d = ST_RETAIN;
                end else if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        tmr_val = CNT_W'(WR_CYC - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_TURN:  if (tmr_done) state_d = ST_IDLE;
            ST_WRITE: if (tmr_done) state_d = ST_IDLE;
            ST_RETAIN: begin
                if (!ret_req) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        req_ready  = 1'b0;
        ret_active = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = !ret_req;
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_WRITE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RETAIN:  ret_active = 1'b1;
            ST_TURN, ST_RECOVER: ;
            default: ;
        endcase
    end

    // R2: write and output enable never low together
    a_r2_no_double_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R2: standby keeps the other strobes quiet
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_we_n && mem_oe_n));
    // R3: read data valid lasts a single clock
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R3: data returns only after a read access
    a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && !is_write_q));
    // R4: address and data stable inside a write pulse
    a_r4_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    // R5: never drive while the memory output may be on
    a_r5_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));
    // R6: one access at a time
    a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: retention keeps the port closed and the memory deselected
    a_r7_retain_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ret_active |-> (mem_cs_n && !req_ready));
    // R8: leaving retention does not reopen the port at once
    a_r8_recover_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ret_active) |-> !req_ready);
endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int RD_CYC   = 4;
    localparam int WR_CYC   = 4;
    localparam int TURN_CYC = 2;
    localparam int REC_CYC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        ret_req = 1'b0;
    logic        ret_active;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ret_req(ret_req),
        .ret_active(ret_active), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: stores on rising write enable, returns garbage until access time
    logic [7:0]  mem [256];
    int          we_run, oe_run, oe_high, last_we_len, last_oe_len;
    int          contention, early_drive, bad_enc;
    logic [18:0] w_addr, last_w_addr;
    logic [7:0]  w_data;
    logic        dq_oe_q;

    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && oe_run >= RD_CYC - 1)
                       ? mem[mem_addr[7:0]] : 8'h5A;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            we_run <= 0; oe_run <= 0; oe_high <= 0;
            last_we_len <= 0; last_oe_len <= 0;
            contention <= 0; early_drive <= 0; bad_enc <= 0;
            w_addr <= '0; last_w_addr <= '0; w_data <= '0; dq_oe_q <= 1'b0;
        end else begin
            if (!mem_we_n) begin
                we_run <= we_run + 1;
                w_addr <= mem_addr;
                w_data <= mem_dq_out;
            end else if (we_run != 0) begin
                last_we_len <= we_run;
                last_w_addr <= w_addr;
                mem[w_addr[7:0]] <= w_data;
                we_run <= 0;
            end
            if (!mem_oe_n) begin
                oe_run  <= oe_run + 1;
                oe_high <= 0;
            end else begin
                if (oe_run != 0) last_oe_len <= oe_run;
                oe_run  <= 0;
                oe_high <= oe_high + 1;
            end
            if (mem_dq_oe && (!mem_oe_n || mem_we_n)) contention <= contention + 1;
            if (mem_dq_oe && !dq_oe_q && oe_high < TURN_CYC) early_drive <= early_drive + 1;
            if ((!mem_we_n && !mem_oe_n) || (mem_cs_n && (!mem_we_n || !mem_oe_n)))
                bad_enc <= bad_enc + 1;
            dq_oe_q <= mem_dq_oe;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R2 write strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        check_eq("R4 write pulse length", last_we_len, WR_CYC);
        check_eq("R4 write address", int'(last_w_addr), int'(a));
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R2 read strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
        while (!rd_valid) @(negedge clk);
        check_eq("R3 read data", rd_data, exp);
        @(negedge clk);
        check_eq("R3 valid pulse width", rd_valid, 0);
        check_eq("R3 output enable length", last_oe_len, RD_CYC);
    endtask

    // {write, addr, data, expected}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 19'h00000, 8'h11, 8'h00},
        {1'b1, 19'h7FFFF, 8'hAA, 8'h00},
        {1'b1, 19'h12345, 8'h3C, 8'h00},
        {1'b0, 19'h7FFFF, 8'h00, 8'hAA},
        {1'b0, 19'h00000, 8'h00, 8'h11},
        {1'b1, 19'h00001, 8'hC3, 8'h00},
        {1'b0, 19'h12345, 8'h00, 8'h3C},
        {1'b0, 19'h00001, 8'h00, 8'hC3}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        check_eq("R1 outputs", {rd_valid, ret_active, req_ready}, 3'b001);

        for (int k = 0; k < 8; k++) begin
            if (VEC[k][35]) do_write(VEC[k][34:16], VEC[k][15:8]);
            else            do_read(VEC[k][34:16], VEC[k][7:0]);
        end

        // Read immediately followed by write: turnaround (R5)
        do_read(19'h00001, 8'hC3);
        do_write(19'h00002, 8'h77);
        do_read(19'h00002, 8'h77);

        // R7: retention wins over a request arriving in the same clock
        @(negedge clk);
        ret_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00002;
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!(mem_cs_n && ret_active && !req_ready)) bad++;
            end
            check_eq("R7 retention holds standby", bad, 0);
        end
        // R8: recovery delay
        ret_req = 1'b0;
        begin
            int n = 0;
            @(negedge clk);
            while (!req_ready) begin
                n++;
                @(negedge clk);
            end
            check_eq("R8 recovery length", n, REC_CYC);
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!rd_valid) @(negedge clk);
        check_eq("R8 pending read after recovery", rd_data, 8'h77);
        repeat (3) @(negedge clk);

        check_eq("R5 driver while output on", contention, 0);
        check_eq("R5 driver before float-off", early_drive, 0);
        check_eq("R2 encoding violations", bad_enc, 0);
        check_eq("R6 idle after traffic", req_ready, 1);
        finish_run();
    end
endmodule